// File: doc/BRIEF.md
# Dual SRAM Byte Bridge

This block lets a narrow CPU bus reach two asynchronous 16-bit SRAM chips as one flat byte space. The CPU drives only 14 address lines, so a 6-bit page register, loaded by the CPU through its own write strobe, supplies the high part of the address. The two lowest CPU address bits are decoded rather than passed on. Bit 0 picks the byte lane inside a 16-bit word. Bit 1 picks the chip. The remaining bits, with the page in front, form the 18-bit word address that both chips share. Together the chips hold 1 MB.

Each access is a single byte read or write with a fixed length set by a parameter. The chip enable, the byte-lane enables and the read or write strobe are driven only to the selected chip, and only while the access lasts. The other chip stays disabled and in low power. The SRAM data pins are brought out as separate output, output-enable and input vectors, and the pad tri-state buffers sit outside the block. The block's drivers default to high impedance. After a read, the block waits one extra idle cycle before it will drive a data bus, so the FPGA and the SRAM never drive the same bus together. No refresh is required.

Top module: `dual_sram_bridge`

## Requirements
- R1: `page_we` loads `page_wdata` into the page register at the clock edge. Accesses accepted after that edge put the page in `sram_addr[17:12]`. An access accepted at the same edge still uses the old page.
- R2: While a chip enable is active, `sram_addr` equals {page, `cpu_addr[13:2]`} as latched when the request was accepted, and it holds steady for the whole access.
- R3: `cpu_addr[1]` selects the chip: 0 gives chip 0 (bit 0 of each per-chip vector), 1 gives chip 1. At most one bit of `sram_ce` is ever high, and the other chip's strobes all stay low.
- R4: `cpu_addr[0]` selects the byte lane: 1 raises `sram_ub` (data bits 15:8), 0 raises `sram_lb` (bits 7:0). Only the selected chip gets a lane enable, and never both lanes at once.
- R5: A read (`cpu_we`=0) raises `sram_ce` and `sram_oe` of the selected chip for exactly WAIT_CYC cycles, starting at the edge that samples the request. `sram_we` and `sram_dq_oe` stay low.
- R6: A write raises `sram_ce`, `sram_we` and `sram_dq_oe` of the selected chip for exactly WAIT_CYC cycles. The chip's 16-bit `sram_dq_o` slice carries the write byte on both halves. `sram_dq_oe` is never high unless that chip's `sram_ce` and `sram_we` are high.
- R7: `cpu_done` is high for exactly one cycle, in the cycle that follows the last access cycle. After a read, `cpu_rdata` then holds the selected lane of the selected chip's `sram_dq_i`, and keeps it until the next read completes.
- R8: After a read, one turnaround cycle follows, and a request in that cycle is ignored. `sram_dq_oe` of a chip is never high in a cycle where that chip's `sram_oe` is high, or was high one cycle earlier.
- R9: A request that arrives while an access is in progress is ignored. The running access continues unchanged, and no extra `cpu_done` is produced.
- R10: A synchronous reset clears the page register, every enable and strobe, `sram_dq_oe`, `cpu_done` and `cpu_rdata`, and it abandons any access in progress.
- R11: While idle, all chip enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | One-cycle access request |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 14 | CPU byte address |
| cpu_wdata | input | 8 | Write byte |
| page_we | input | 1 | Page register load strobe |
| page_wdata | input | 6 | New page value |
| cpu_rdata | output | 8 | Read byte |
| cpu_done | output | 1 | Access complete pulse |
| sram_addr | output | 18 | Shared word address |
| sram_ce | output | 2 | Per-chip enable, active high |
| sram_oe | output | 2 | Per-chip output enable, active high |
| sram_we | output | 2 | Per-chip write strobe, active high |
| sram_ub | output | 2 | Per-chip upper-lane enable |
| sram_lb | output | 2 | Per-chip lower-lane enable |
| sram_dq_o | output | 32 | Write data, chip c in bits 16c+15:16c |
| sram_dq_oe | output | 2 | Per-chip data driver enable |
| sram_dq_i | input | 32 | Data read from pads, same layout |

## Verification
Every SRAM strobe is registered, so the strobes rise at the same edge that samples `cpu_req` and fall exactly WAIT_CYC edges later. At that falling edge `cpu_done` and the captured `cpu_rdata` appear together. A turnaround cycle follows each read, which puts the earliest accepted follow-up request two edges after the done edge. The bench's behavioural model steps through these same edge counts and is compared with every output at each falling clock edge, where all registered values have settled. Requests placed inside an access and inside the turnaround cycle check that those edges are ignored.

// File: rtl/sbr_pkg.sv
package sbr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACC  = 2'd1,
    ST_TURN = 2'd2
  } sbr_state_e;
endpackage

// File: rtl/sbr_page_reg.sv
module sbr_page_reg #(
  parameter int PAGE_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [PAGE_W-1:0] load_val,
  output logic [PAGE_W-1:0] page
);
  always_ff @(posedge clk) begin
    if (rst) page <= '0;
    else if (load) page <= load_val;
  end
endmodule

// File: rtl/sbr_decode.sv
module sbr_decode #(
  parameter int PAGE_W = 6,
  parameter int CPU_AW = 14,
  parameter int CHIPS  = 2,
  localparam int CB    = $clog2(CHIPS),
  localparam int SAW   = PAGE_W + CPU_AW - 1 - CB
) (
  input  logic [PAGE_W-1:0] page,
  input  logic [CPU_AW-1:0] cpu_addr,
  output logic [SAW-1:0]    word_addr,
  output logic [CB-1:0]     chip_idx,
  output logic [CHIPS-1:0]  chip_sel,
  output logic              upper
);
  assign upper     = cpu_addr[0];
  assign chip_idx  = cpu_addr[1 +: CB];
  assign word_addr = {page, cpu_addr[CPU_AW-1:1+CB]};

  for (genvar c = 0; c < CHIPS; c++) begin : g_sel
    assign chip_sel[c] = (chip_idx == CB'(c));
  end
endmodule

// File: rtl/sbr_seq.sv
module sbr_seq
  import sbr_pkg::*;
#(
  parameter int WAIT_CYC = 2,
  localparam int CW      = $clog2(WAIT_CYC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic req_wr,
  output logic accept,
  output logic finish,
  output logic wr_q
);
  sbr_state_e    st;
  logic [CW-1:0] cnt;

  assign accept = (st == ST_IDLE) && req;
  assign finish = (st == ST_ACC) && (cnt == CW'(WAIT_CYC - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= ST_IDLE;
      cnt  <= '0;
      wr_q <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (req) begin
          st   <= ST_ACC;
          cnt  <= '0;
          wr_q <= req_wr;
        end
        ST_ACC: begin
          if (finish) st <= wr_q ? ST_IDLE : ST_TURN;
          else        cnt <= cnt + CW'(1);
        end
        ST_TURN: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sbr_lanes.sv
module sbr_lanes #(
  parameter int CHIPS = 2,
  parameter int DW    = 8,
  parameter int SAW   = 18,
  localparam int CB   = $clog2(CHIPS),
  localparam int SDW  = 2 * DW
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 accept,
  input  logic                 finish,
  input  logic                 req_wr,
  input  logic                 wr_q,
  input  logic [CHIPS-1:0]     chip_sel,
  input  logic [CB-1:0]        chip_idx,
  input  logic                 upper,
  input  logic [SAW-1:0]       word_addr,
  input  logic [DW-1:0]        wdata,
  input  logic [CHIPS*SDW-1:0] dq_i,
  output logic [SAW-1:0]       sram_addr,
  output logic [CHIPS-1:0]     sram_ce,
  output logic [CHIPS-1:0]     sram_oe,
  output logic [CHIPS-1:0]     sram_we,
  output logic [CHIPS-1:0]     sram_ub,
  output logic [CHIPS-1:0]     sram_lb,
  output logic [CHIPS-1:0]     sram_dq_oe,
  output logic [CHIPS*SDW-1:0] sram_dq_o,
  output logic [DW-1:0]        rdata,
  output logic                 done
);
  logic [CB-1:0]  idx_q;
  logic           up_q;
  logic [SDW-1:0] rword;

  always_ff @(posedge clk) begin
    if (rst) begin
      sram_addr <= '0;
      idx_q     <= '0;
      up_q      <= 1'b0;
    end else if (accept) begin
      sram_addr <= word_addr;
      idx_q     <= chip_idx;
      up_q      <= upper;
    end
  end

  for (genvar c = 0; c < CHIPS; c++) begin : g_chip
    always_ff @(posedge clk) begin
      if (rst) begin
        sram_ce[c]    <= 1'b0;
        sram_oe[c]    <= 1'b0;
        sram_we[c]    <= 1'b0;
        sram_ub[c]    <= 1'b0;
        sram_lb[c]    <= 1'b0;
        sram_dq_oe[c] <= 1'b0;
      end else if (accept) begin
        sram_ce[c]    <= chip_sel[c];
        sram_oe[c]    <= chip_sel[c] & ~req_wr;
        sram_we[c]    <= chip_sel[c] & req_wr;
        sram_ub[c]    <= chip_sel[c] & upper;
        sram_lb[c]    <= chip_sel[c] & ~upper;
        sram_dq_oe[c] <= chip_sel[c] & req_wr;
      end else if (finish) begin
        sram_ce[c]    <= 1'b0;
        sram_oe[c]    <= 1'b0;
        sram_we[c]    <= 1'b0;
        sram_ub[c]    <= 1'b0;
        sram_lb[c]    <= 1'b0;
        sram_dq_oe[c] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) sram_dq_o[c*SDW +: SDW] <= '0;
      else if (accept && chip_sel[c] && req_wr) sram_dq_o[c*SDW +: SDW] <= {wdata, wdata};
    end
  end

  assign rword = dq_i[idx_q*SDW +: SDW];

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      done  <= 1'b0;
    end else begin
      done <= finish;
      if (finish && !wr_q) rdata <= up_q ? rword[SDW-1:DW] : rword[DW-1:0];
    end
  end
endmodule

// File: rtl/dual_sram_bridge.sv
module dual_sram_bridge #(
  parameter int PAGE_W   = 6,
  parameter int CPU_AW   = 14,
  parameter int CHIPS    = 2,
  parameter int DW       = 8,
  parameter int WAIT_CYC = 2,
  localparam int CB      = $clog2(CHIPS),
  localparam int SAW     = PAGE_W + CPU_AW - 1 - CB,
  localparam int SDW     = 2 * DW
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cpu_req,
  input  logic                 cpu_we,
  input  logic [CPU_AW-1:0]    cpu_addr,
  input  logic [DW-1:0]        cpu_wdata,
  input  logic                 page_we,
  input  logic [PAGE_W-1:0]    page_wdata,
  output logic [DW-1:0]        cpu_rdata,
  output logic                 cpu_done,
  output logic [SAW-1:0]       sram_addr,
  output logic [CHIPS-1:0]     sram_ce,
  output logic [CHIPS-1:0]     sram_oe,
  output logic [CHIPS-1:0]     sram_we,
  output logic [CHIPS-1:0]     sram_ub,
  output logic [CHIPS-1:0]     sram_lb,
  output logic [CHIPS*SDW-1:0] sram_dq_o,
  output logic [CHIPS-1:0]     sram_dq_oe,
  input  logic [CHIPS*SDW-1:0] sram_dq_i
);
  logic [PAGE_W-1:0] page;
  logic [SAW-1:0]    word_addr;
  logic [CB-1:0]     chip_idx;
  logic [CHIPS-1:0]  chip_sel;
  logic              upper, accept, finish, wr_q;

  sbr_page_reg #(.PAGE_W(PAGE_W)) u_page (
    .clk(clk), .rst(rst), .load(page_we), .load_val(page_wdata), .page(page)
  );

  sbr_decode #(.PAGE_W(PAGE_W), .CPU_AW(CPU_AW), .CHIPS(CHIPS)) u_dec (
    .page(page), .cpu_addr(cpu_addr), .word_addr(word_addr),
    .chip_idx(chip_idx), .chip_sel(chip_sel), .upper(upper)
  );

  sbr_seq #(.WAIT_CYC(WAIT_CYC)) u_seq (
    .clk(clk), .rst(rst), .req(cpu_req), .req_wr(cpu_we),
    .accept(accept), .finish(finish), .wr_q(wr_q)
  );

  sbr_lanes #(.CHIPS(CHIPS), .DW(DW), .SAW(SAW)) u_lanes (
    .clk(clk), .rst(rst), .accept(accept), .finish(finish),
    .req_wr(cpu_we), .wr_q(wr_q), .chip_sel(chip_sel), .chip_idx(chip_idx),
    .upper(upper), .word_addr(word_addr), .wdata(cpu_wdata), .dq_i(sram_dq_i),
    .sram_addr(sram_addr), .sram_ce(sram_ce), .sram_oe(sram_oe),
    .sram_we(sram_we), .sram_ub(sram_ub), .sram_lb(sram_lb),
    .sram_dq_oe(sram_dq_oe), .sram_dq_o(sram_dq_o),
    .rdata(cpu_rdata), .done(cpu_done)
  );
endmodule

// File: rtl/sbr_checker.sv
module sbr_checker #(
  parameter int CHIPS = 2,
  parameter int SAW   = 18
) (
  input logic             clk,
  input logic             rst,
  input logic [CHIPS-1:0] sram_ce,
  input logic [CHIPS-1:0] sram_oe,
  input logic [CHIPS-1:0] sram_we,
  input logic [CHIPS-1:0] sram_ub,
  input logic [CHIPS-1:0] sram_lb,
  input logic [CHIPS-1:0] sram_dq_oe,
  input logic [SAW-1:0]   sram_addr,
  input logic             cpu_done
);
  assert_one_chip_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sram_ce));

  assert_lane_R4: assert property (@(posedge clk) disable iff (rst)
    ((sram_ub | sram_lb) == sram_ce) && ((sram_ub & sram_lb) == '0));

  assert_no_rw_R5: assert property (@(posedge clk) disable iff (rst)
    (sram_oe & sram_we) == '0);

  assert_drive_owner_R6: assert property (@(posedge clk) disable iff (rst)
    (sram_dq_oe & ~(sram_ce & sram_we)) == '0);

  assert_turnaround_R8: assert property (@(posedge clk) disable iff (rst)
    (sram_dq_oe & (sram_oe | $past(sram_oe))) == '0);

  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (rst)
    ((sram_ce != '0) && ($past(sram_ce) != '0)) |-> $stable(sram_addr));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    cpu_done |=> !cpu_done);

  assert_reset_clear_R10: assert property (@(posedge clk)
    rst |=> ((sram_ce == '0) && (sram_dq_oe == '0) && !cpu_done));
endmodule

bind dual_sram_bridge sbr_checker #(.CHIPS(CHIPS), .SAW(SAW)) u_sbr_chk (
  .clk(clk), .rst(rst), .sram_ce(sram_ce), .sram_oe(sram_oe),
  .sram_we(sram_we), .sram_ub(sram_ub), .sram_lb(sram_lb),
  .sram_dq_oe(sram_dq_oe), .sram_addr(sram_addr), .cpu_done(cpu_done)
);

// File: tb/dual_sram_bridge_test.sv
`timescale 1ns/1ps
module dual_sram_bridge_test;
  localparam int WAIT = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_req = 1'b0, cpu_we = 1'b0, page_we = 1'b0;
  logic [13:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic [5:0]  page_wdata = '0;
  logic [7:0]  cpu_rdata;
  logic        cpu_done;
  logic [17:0] sram_addr;
  logic [1:0]  sram_ce, sram_oe, sram_we, sram_ub, sram_lb, sram_dq_oe;
  logic [31:0] sram_dq_o;
  logic [31:0] sram_dq_i;

  int n_tests = 0, n_fail = 0, cyc = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dual_sram_bridge #(.WAIT_CYC(WAIT)) uut (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .page_we(page_we),
    .page_wdata(page_wdata), .cpu_rdata(cpu_rdata), .cpu_done(cpu_done),
    .sram_addr(sram_addr), .sram_ce(sram_ce), .sram_oe(sram_oe),
    .sram_we(sram_we), .sram_ub(sram_ub), .sram_lb(sram_lb),
    .sram_dq_o(sram_dq_o), .sram_dq_oe(sram_dq_oe), .sram_dq_i(sram_dq_i)
  );

  function automatic logic [15:0] dflt(int chip, logic [17:0] w);
    return w[15:0] ^ ((chip != 0) ? 16'h3C96 : 16'hA5C3);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // SRAM pin model: two chips, byte-lane writes
  logic [15:0] pmem [int];
  always @(posedge clk) begin
    if (!rst) begin
      for (int c = 0; c < 2; c++) begin
        if (sram_ce[c] && sram_we[c] && sram_dq_oe[c]) begin
          logic [15:0] w;
          int key;
          key = c * (1 << 18) + int'(sram_addr);
          w = pmem.exists(key) ? pmem[key] : dflt(c, sram_addr);
          if (sram_ub[c]) w[15:8] = sram_dq_o[c*16+8 +: 8];
          if (sram_lb[c]) w[7:0]  = sram_dq_o[c*16 +: 8];
          pmem[key] = w;
        end
      end
    end
  end
  always @(*) begin
    for (int c = 0; c < 2; c++) begin
      int key;
      key = c * (1 << 18) + int'(sram_addr);
      if (sram_ce[c] && sram_oe[c])
        sram_dq_i[c*16 +: 16] = pmem.exists(key) ? pmem[key] : dflt(c, sram_addr);
      else
        sram_dq_i[c*16 +: 16] = 16'h0000;
    end
  end

  // Behavioural reference model, updated each rising edge
  bit          m_started = 0, m_act = 0, m_turn = 0, m_wr = 0, m_done = 0, m_up = 0;
  int          m_cnt = 0, m_chip = 0, m_ba = 0;
  logic [5:0]  m_page = '0;
  logic [17:0] m_addr = '0;
  logic [1:0]  m_ce = '0, m_oe = '0, m_we = '0, m_ub = '0, m_lb = '0, m_dqoe = '0;
  logic [15:0] m_wd = '0;
  logic [7:0]  m_rdata = '0;
  logic [7:0]  bmem [int];

  task automatic m_clear();
    m_ce = '0; m_oe = '0; m_we = '0; m_ub = '0; m_lb = '0; m_dqoe = '0;
  endtask

  always @(posedge clk) begin
    m_started = 1;
    if (rst) begin
      m_act = 0; m_turn = 0; m_done = 0; m_page = '0; m_rdata = '0;
      m_clear();
    end else begin
      m_done = 0;
      if (m_act) begin
        if (m_cnt == WAIT - 1) begin
          m_act = 0; m_done = 1; m_turn = !m_wr;
          m_clear();
          if (!m_wr) begin
            logic [15:0] d;
            d = dflt(m_chip, m_addr);
            m_rdata = bmem.exists(m_ba) ? bmem[m_ba] : (m_up ? d[15:8] : d[7:0]);
          end
        end else m_cnt++;
      end else if (m_turn) begin
        m_turn = 0;
      end else if (cpu_req) begin
        m_act = 1; m_cnt = 0; m_wr = cpu_we;
        m_chip = int'(cpu_addr[1]); m_up = cpu_addr[0];
        m_addr = {m_page, cpu_addr[13:2]};
        m_ba = int'({m_page, cpu_addr});
        m_clear();
        m_ce[m_chip] = 1'b1;
        m_oe[m_chip] = !cpu_we;
        m_we[m_chip] = cpu_we;
        m_dqoe[m_chip] = cpu_we;
        m_ub[m_chip] = m_up;
        m_lb[m_chip] = !m_up;
        m_wd = {cpu_wdata, cpu_wdata};
        if (cpu_we) bmem[m_ba] = cpu_wdata;
      end
      if (page_we) m_page = page_wdata;
    end
  end

  // Compare every output each falling edge
  always @(negedge clk) begin
    if (m_started && !finished) begin
      check("R3 sram_ce", 32'(sram_ce), 32'(m_ce));
      check("R5 sram_oe", 32'(sram_oe), 32'(m_oe));
      check("R6 sram_we", 32'(sram_we), 32'(m_we));
      check("R4 sram_ub", 32'(sram_ub), 32'(m_ub));
      check("R4 sram_lb", 32'(sram_lb), 32'(m_lb));
      check("R8 sram_dq_oe", 32'(sram_dq_oe), 32'(m_dqoe));
      check("R7 cpu_done", 32'(cpu_done), 32'(m_done));
      check("R7 cpu_rdata", 32'(cpu_rdata), 32'(m_rdata));
      if (m_ce != '0) check("R2 sram_addr", 32'(sram_addr), 32'(m_addr));
      for (int c = 0; c < 2; c++)
        if (m_dqoe[c]) check("R6 sram_dq_o", 32'(sram_dq_o[c*16 +: 16]), 32'(m_wd));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !finished) begin
      finished = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<20000 cycles", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic access(bit w, logic [13:0] a, logic [7:0] d);
    cpu_req = 1'b1; cpu_we = w; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_req = 1'b0;
    while (!cpu_done) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic set_page(logic [5:0] p);
    page_we = 1'b1; page_wdata = p;
    @(negedge clk);
    page_we = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check("R10 reset ce", 32'(sram_ce), 0);
    check("R10 reset dq_oe", 32'(sram_dq_oe), 0);
    check("R10 reset done", 32'(cpu_done), 0);
    check("R10 reset rdata", 32'(cpu_rdata), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R11 idle ce", 32'(sram_ce), 0);

    // reads of untouched words, all four lane/chip combinations
    for (int k = 0; k < 4; k++) access(1'b0, 14'h1230 | 14'(k), 8'h00);

    // page then writes to every lane/chip, read back
    set_page(6'h2B);
    for (int k = 0; k < 4; k++) access(1'b1, 14'h0A40 | 14'(k), 8'h11 * 8'(k + 1));
    for (int k = 0; k < 4; k++) access(1'b0, 14'h0A40 | 14'(k), 8'h00);

    // page value appears on the shared address
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 14'h3FFF;
    @(negedge clk);
    cpu_req = 1'b0;
    check("R1 page on sram_addr", 32'(sram_addr[17:12]), 32'h2B);
    check("R3 chip 1 selected", 32'(sram_ce), 32'b10);
    check("R4 upper lane", 32'(sram_ub), 32'b10);
    // request while busy is ignored
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 14'h0000; cpu_wdata = 8'hEE;
    @(negedge clk);
    cpu_req = 1'b0;
    check("R9 busy request ignored", 32'(sram_ce), 32'b10);
    check("R9 no write strobe", 32'(sram_we), 0);
    while (!cpu_done) @(negedge clk);
    // request in turnaround cycle is ignored
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 14'h0005; cpu_wdata = 8'h77;
    @(negedge clk);
    cpu_req = 1'b0;
    check("R8 turnaround request ignored", 32'(sram_ce), 0);
    check("R8 no drive in turnaround", 32'(sram_dq_oe), 0);
    @(negedge clk);
    check("R11 idle after turnaround", 32'(sram_ce), 0);

    // write after read with page change in same cycle as request
    access(1'b0, 14'h0003, 8'h00);
    page_we = 1'b1; page_wdata = 6'h05;
    access(1'b1, 14'h0102, 8'hC7);
    page_we = 1'b0;
    check("R1 old page used at load edge", 32'(sram_addr[17:12]), 32'h2B);
    access(1'b0, 14'h0102, 8'h00);
    check("R1 new page used", 32'(sram_addr[17:12]), 32'h05);
    access(1'b1, 14'h0103, 8'h5E);
    access(1'b0, 14'h0103, 8'h00);
    access(1'b0, 14'h0102, 8'h00);

    // reset during a write
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 14'h0201; cpu_wdata = 8'h99;
    @(negedge clk);
    cpu_req = 1'b0; rst = 1'b1;
    @(negedge clk);
    check("R10 abandon ce", 32'(sram_ce), 0);
    check("R10 abandon dq_oe", 32'(sram_dq_oe), 0);
    rst = 1'b0;
    @(negedge clk);
    access(1'b0, 14'h3001, 8'h00);
    check("R10 page cleared", 32'(sram_addr[17:12]), 0);
    repeat (3) @(negedge clk);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule